// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Interface

This block is the private interrupt front end of one processor core. It watches a small set of interrupt sources, each with its own 8-bit priority value (lower value means more urgent). It keeps a pending bit per source, which is latched on a rising edge or follows the line level, and an active bit per source. From these it picks the most urgent candidate and raises the core's IRQ line when three things hold: signalling is enabled, the candidate's priority is below a programmable mask, and it is more urgent than the priority the core is already running at.

Software drives it through a small word-addressed register port. It reads the acknowledge register to claim the candidate, which marks it active and raises the running priority. It writes that same value to the end register to retire it, which drops the running priority back to the previous nesting level. A stack of running priorities lets more urgent interrupts preempt handlers that are already running. The usual service loop reads acknowledge, handles, writes end, and repeats until it reads the spurious ID 1023. For that loop to work, the next candidate becomes visible in the cycle right after each end write.

Register word addresses: 0 control (bit 0 enables signalling), 1 priority mask (bits 7:0), 2 acknowledge (read, with side effects), 3 end of interrupt (write), 4 running priority (read), 5 highest pending (read, no side effects). Read data is registered and appears one cycle after the read strobe. A read strobe issued together with a write strobe is dropped.

Top module: `core_irq_if`

## Requirements
- R1: After reset the IRQ output is low, control reads 0, the priority mask reads 0, running priority reads 0xFF, and both acknowledge and highest pending read 1023.
- R2: While control bit 0 is clear, the IRQ output stays low and an acknowledge read returns 1023 without changing pending, active or running-priority state.
- R3: A candidate with priority value p is signalled only if p is strictly less than the mask value m. A mask of 0 blocks everything; a mask of 0xFF passes every priority except 0xFF.
- R4: The candidate is the pending, non-active source with the lowest priority value; on equal values the lower ID wins. Highest pending returns its packed value, or 1023 when there is no candidate, and has no side effects.
- R5: Acknowledge and highest-pending values carry the ID in bits 9:0. Bits 12:10 hold the requesting core number for software sources (IDs below N_SGI, taken from sgi_core) and 0 for other sources. Bits 31:13 are 0.
- R6: An acknowledge read that returns a real ID sets that source active and makes running priority equal to its priority value. A level source whose line stays high is not offered again while it is active.
- R7: A candidate is signalled only if its priority value is strictly less than the running priority; an equal value does not preempt. A nested acknowledge pushes a new running level.
- R8: An end write whose bits 9:0 name an active ID clears that ID's active bit and restores the previous running priority. Any candidate that now qualifies drives IRQ high in the cycle after the write.
- R9: An end write naming an ID that is not active (including 1022 and 1023) changes nothing: running priority and active state stay the same.
- R10: A software source, or a source with its edge_mode bit set, becomes pending on a rising edge of its request line. An acknowledge clears that pending bit, and a line that stays high does not make the source pending again.
- R11: An acknowledge read when nothing qualifies (no candidate, masked, or not more urgent than the running priority) returns 1023 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| irq_req | input | N_SRC | Request line per source |
| edge_mode | input | N_SRC | 1 = rising-edge capture, 0 = level; ignored for software sources, which are always edge |
| src_prio | input | 8*N_SRC | Priority value per source, source i in bits 8i+7:8i |
| sgi_core | input | 3*N_SGI | Requesting core number per software source, source i in bits 3i+2:3i |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; acknowledge reads have side effects |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The hardest state to reach is a two-deep nesting in which a third, less urgent source is pending but held off only by the running priority, and in which end writes naming pending-but-not-active and spurious IDs must leave the stack untouched. The bench gets there by holding a low-urgency level line, acknowledging it, then raising a more urgent line and acknowledging that too, and only then raising a middle-priority line. It releases the inner line before retiring it so the pop can be seen on IRQ and running priority in the cycle after the write. Separate sweeps cover the mask comparison at and around each boundary, and every request pattern over six sources against a computed arbitration.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int ID_W   = 10;
  localparam int CORE_W = 3;
  localparam int PRIO_W = 8;
  localparam logic [31:0] SPUR_WORD = 32'd1023;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_PMASK  = 3'd1,
    REG_ACK    = 3'd2,
    REG_EOI    = 3'd3,
    REG_RUNPRI = 3'd4,
    REG_HIPEND = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/cif_pend_track.sv
module cif_pend_track #(
  parameter int N_SRC = 8,
  parameter int N_SGI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] take_clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] latch_q, latch_n;
  logic [N_SRC-1:0] use_edge;

  // rising edge sets, a claim clears; a new edge in the claim cycle wins
  assign latch_n = (latch_q & ~take_clr) | (req & ~req_q);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam bit IS_SGI = (i < N_SGI);
    assign use_edge[i] = edge_mode[i] | IS_SGI;
    assign pend[i]     = use_edge[i] ? latch_q[i] : req[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      latch_q <= '0;
    end else begin
      req_q   <= req;
      latch_q <= latch_n;
    end
  end
endmodule

// File: rtl/cif_select.sv
module cif_select #(
  parameter int N_SRC = 8,
  parameter int SRC_W = 3
) (
  input  logic [N_SRC-1:0]   cand,
  input  logic [N_SRC*8-1:0] prio,
  output logic               found,
  output logic [SRC_W-1:0]   win_id,
  output logic [7:0]         win_prio
);
  // strict compare keeps the lower index on equal priority values
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = 8'hFF;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!found || (prio[i*8 +: 8] < win_prio))) begin
        found    = 1'b1;
        win_id   = SRC_W'(i);
        win_prio = prio[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/cif_rpri_stack.sv
module cif_rpri_stack #(
  parameter int DEPTH = 8,
  parameter int SP_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [7:0]      push_prio,
  output logic [7:0]      top_prio,
  output logic [SP_W-1:0] depth
);
  logic [7:0]      slot_q [DEPTH];
  logic [7:0]      slot_n [DEPTH];
  logic [SP_W-1:0] sp_q, sp_n;

  always_comb begin
    slot_n = slot_q;
    sp_n   = sp_q;
    if (push && (sp_q < SP_W'(DEPTH))) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (SP_W'(i) == sp_q) slot_n[i] = push_prio;
      end
      sp_n = sp_q + 1'b1;
    end else if (pop && (sp_q != '0)) begin
      sp_n = sp_q - 1'b1;
    end
  end

  always_comb begin
    top_prio = 8'hFF;
    for (int i = 0; i < DEPTH; i++) begin
      if (SP_W'(i + 1) == sp_q) top_prio = slot_q[i];
    end
  end

  assign depth = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  always_ff @(posedge clk) begin
    if (push) slot_q <= slot_n;
  end
endmodule

// File: rtl/core_irq_if.sv
module core_irq_if
  import cif_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_SGI = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   irq_req,
  input  logic [N_SRC-1:0]   edge_mode,
  input  logic [N_SRC*8-1:0] src_prio,
  input  logic [N_SGI*3-1:0] sgi_core,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_rd,
  output logic [31:0]        reg_rdata,
  output logic               irq_o
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int SP_W  = $clog2(N_SRC + 1);

  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic             ctrl_en_q, ctrl_en_n;
  logic [7:0]       pmask_q, pmask_n;
  logic [N_SRC-1:0] active_q, active_n;
  logic [31:0]      rdata_q, rdata_n;

  logic [N_SRC-1:0]  pend, cand, take_clr;
  logic              found;
  logic [SRC_W-1:0]  win_id;
  logic [7:0]        win_prio, run_pri;
  logic [SP_W-1:0]   depth;
  logic [CORE_W-1:0] win_core;
  logic [ID_W-1:0]   win_id_ext;
  logic [31:0]       win_word, hipend_word;
  logic              rd_go, ack_rd, take, eoi_wr, eoi_hit, qualify;
  logic [ID_W-1:0]   eoi_id;
  logic [SRC_W-1:0]  eoi_idx;
  logic              unused_bits;

  cif_pend_track #(.N_SRC(N_SRC), .N_SGI(N_SGI)) u_pend (
    .clk(clk), .rst_n(rst_sn), .req(irq_req), .edge_mode(edge_mode),
    .take_clr(take_clr), .pend(pend)
  );

  assign cand = pend & ~active_q;

  cif_select #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_sel (
    .cand(cand), .prio(src_prio), .found(found),
    .win_id(win_id), .win_prio(win_prio)
  );

  cif_rpri_stack #(.DEPTH(N_SRC), .SP_W(SP_W)) u_stack (
    .clk(clk), .rst_n(rst_sn), .push(take), .pop(eoi_hit),
    .push_prio(win_prio), .top_prio(run_pri), .depth(depth)
  );

  assign qualify = ctrl_en_q & found & (win_prio < pmask_q) & (win_prio < run_pri);
  assign irq_o   = qualify;

  always_comb begin
    win_core = '0;
    for (int s = 0; s < N_SGI; s++) begin
      if (win_id == SRC_W'(s)) win_core = sgi_core[s*CORE_W +: CORE_W];
    end
  end

  assign win_id_ext  = ID_W'(win_id);
  assign win_word    = {{(32-CORE_W-ID_W){1'b0}}, win_core, win_id_ext};
  assign hipend_word = found ? win_word : SPUR_WORD;

  assign rd_go   = reg_rd & ~reg_wr;
  assign ack_rd  = rd_go && (reg_addr == REG_ACK);
  assign take    = ack_rd & qualify;
  assign eoi_wr  = reg_wr && (reg_addr == REG_EOI);
  assign eoi_id  = reg_wdata[ID_W-1:0];
  assign eoi_idx = eoi_id[SRC_W-1:0];
  assign eoi_hit = eoi_wr && (eoi_id < ID_W'(N_SRC)) && active_q[eoi_idx];

  assign unused_bits = ^{reg_wdata[31:ID_W], depth};

  always_comb begin
    take_clr = '0;
    if (take) take_clr[win_id] = 1'b1;
  end

  always_comb begin
    ctrl_en_n = ctrl_en_q;
    pmask_n   = pmask_q;
    active_n  = active_q;
    rdata_n   = rdata_q;
    if (reg_wr) begin
      case (reg_sel_e'(reg_addr))
        REG_CTRL:  ctrl_en_n = reg_wdata[0];
        REG_PMASK: pmask_n   = reg_wdata[7:0];
        default:   ;
      endcase
    end
    if (take)    active_n[win_id]  = 1'b1;
    if (eoi_hit) active_n[eoi_idx] = 1'b0;
    if (rd_go) begin
      case (reg_sel_e'(reg_addr))
        REG_CTRL:   rdata_n = {31'd0, ctrl_en_q};
        REG_PMASK:  rdata_n = {24'd0, pmask_q};
        REG_ACK:    rdata_n = qualify ? win_word : SPUR_WORD;
        REG_RUNPRI: rdata_n = {24'd0, run_pri};
        REG_HIPEND: rdata_n = hipend_word;
        default:    rdata_n = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_en_q <= 1'b0;
      pmask_q   <= 8'h00;
      active_q  <= '0;
      rdata_q   <= '0;
    end else begin
      ctrl_en_q <= ctrl_en_n;
      pmask_q   <= pmask_n;
      active_q  <= active_n;
      rdata_q   <= rdata_n;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/cif_checker.sv
module cif_checker
  import cif_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SRC_W = 3,
  parameter int SP_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [ID_W-1:0]  eoi_field,
  input logic [31:0]      reg_rdata,
  input logic             ctrl_en,
  input logic [7:0]       pmask,
  input logic [7:0]       run_pri,
  input logic [7:0]       win_prio,
  input logic [N_SRC-1:0] active,
  input logic [SP_W-1:0]  depth
);
  logic ack_req, eoi_miss;
  assign ack_req  = reg_rd && !reg_wr && (reg_addr == REG_ACK);
  assign eoi_miss = reg_wr && (reg_addr == REG_EOI) &&
                    !((eoi_field < ID_W'(N_SRC)) && active[eoi_field[SRC_W-1:0]]);

  assert_off_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq_o);

  assert_below_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_prio < pmask));

  assert_preempt_strict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_prio < run_pri));

  assert_claim_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq_o) |=> (run_pri == $past(win_prio)) && (depth == $past(depth) + 1'b1));

  assert_depth_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    depth == SP_W'($countones(active)));

  assert_spurious_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !irq_o) |=> (reg_rdata == SPUR_WORD) && $stable(run_pri) && $stable(active));

  assert_eoi_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_miss |=> $stable(run_pri) && $stable(active));
endmodule

bind core_irq_if cif_checker #(.N_SRC(N_SRC), .SRC_W(SRC_W), .SP_W(SP_W)) u_cif_checker (
  .clk(clk), .rst_n(rst_sn), .irq_o(irq_o), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .eoi_field(reg_wdata[9:0]), .reg_rdata(reg_rdata),
  .ctrl_en(ctrl_en_q), .pmask(pmask_q), .run_pri(run_pri), .win_prio(win_prio),
  .active(active_q), .depth(depth)
);

// File: tb/tb_core_irq_if.sv
module tb_core_irq_if;
  localparam int N = 8;
  localparam int G = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req;
  logic [N-1:0]  edge_mode;
  logic [N*8-1:0] src_prio;
  logic [G*3-1:0] sgi_core;
  logic [2:0]    reg_addr;
  logic          reg_wr;
  logic [31:0]   reg_wdata;
  logic          reg_rd;
  logic [31:0]   reg_rdata;
  logic          irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] rv;
  logic [7:0]  pr [N];

  always #5 clk = ~clk;

  core_irq_if #(.N_SRC(N), .N_SGI(G)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .edge_mode(edge_mode),
    .src_prio(src_prio), .sgi_core(sgi_core), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_prio(input int i, input logic [7:0] v);
    pr[i] = v;
    src_prio[i*8 +: 8] = v;
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    #1;
    chk(tag, {31'd0, irq_o}, {31'd0, exp});
  endtask

  function automatic logic [31:0] exp_hipend(input logic [N-1:0] pat);
    int best = -1;
    for (int i = 2; i < N; i++)
      if (pat[i] && (best < 0 || pr[i] < pr[best])) best = i;
    return (best < 0) ? 32'd1023 : 32'(best);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; edge_mode = '0; src_prio = '0;
    sgi_core = {3'd2, 3'd5};
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
    for (int i = 0; i < N; i++) set_prio(i, 8'h80);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_irq("R1 irq after reset", 1'b0);
    rd(3'd4, rv); chk("R1 runpri", rv, 32'hFF);
    rd(3'd0, rv); chk("R1 ctrl", rv, 32'd0);
    rd(3'd1, rv); chk("R1 mask", rv, 32'd0);
    rd(3'd2, rv); chk("R1 ack spurious", rv, 32'd1023);
    rd(3'd5, rv); chk("R1 hipend none", rv, 32'd1023);

    // R2 disabled interface
    set_prio(5, 8'h30); irq_req[5] = 1'b1;
    wr(3'd1, 32'hFF);
    chk_irq("R2 irq low while disabled", 1'b0);
    rd(3'd2, rv); chk("R2 ack spurious while disabled", rv, 32'd1023);
    rd(3'd4, rv); chk("R2 runpri untouched", rv, 32'hFF);
    rd(3'd5, rv); chk("R2 still pending", rv, 32'd5);
    wr(3'd0, 32'd1);
    chk_irq("R2 irq once enabled", 1'b1);

    // R3 mask sweep around every boundary
    for (int p = 0; p < 256; p += 17) begin
      set_prio(5, 8'(p));
      for (int k = 0; k < 5; k++) begin
        int m;
        m = (k == 0) ? p : (k == 1) ? ((p + 1) & 255) : (k == 2) ? 0 :
            (k == 3) ? 255 : ((p + 255) & 255);
        wr(3'd1, 32'(m));
        chk_irq($sformatf("R3 p=%0d m=%0d", p, m), p < m);
      end
    end
    wr(3'd1, 32'hFF);
    irq_req[5] = 1'b0;

    // R4/R5 arbitration sweep over sources 2..7, with ties
    set_prio(2, 8'h60); set_prio(3, 8'h20); set_prio(4, 8'h10);
    set_prio(5, 8'h30); set_prio(6, 8'h10); set_prio(7, 8'h20);
    for (int pat = 0; pat < 64; pat++) begin
      irq_req = N'(pat << 2);
      rd(3'd5, rv);
      chk($sformatf("R4 R5 hipend pat=%0h", pat), rv, exp_hipend(irq_req));
      chk_irq($sformatf("R4 irq pat=%0h", pat), pat != 0);
    end
    irq_req = '0;
    rd(3'd4, rv); chk("R4 hipend reads left runpri idle", rv, 32'hFF);

    // R6 R7 R8 R9 nested handling
    set_prio(7, 8'h70); set_prio(3, 8'h20); set_prio(5, 8'h30);
    irq_req[7] = 1'b1;
    rd(3'd2, rv); chk("R6 ack src7", rv, 32'd7);
    rd(3'd4, rv); chk("R6 runpri 70", rv, 32'h70);
    chk_irq("R6 active level not reoffered", 1'b0);
    rd(3'd5, rv); chk("R6 hipend empty while active", rv, 32'd1023);
    irq_req[3] = 1'b1;
    chk_irq("R7 more urgent preempts", 1'b1);
    rd(3'd2, rv); chk("R7 nested ack src3", rv, 32'd3);
    rd(3'd4, rv); chk("R7 runpri 20", rv, 32'h20);
    irq_req[5] = 1'b1;
    chk_irq("R7 less urgent held off", 1'b0);
    rd(3'd5, rv); chk("R7 hipend src5", rv, 32'd5);
    rd(3'd2, rv); chk("R11 ack held-off spurious", rv, 32'd1023);
    wr(3'd3, 32'd1023);
    rd(3'd4, rv); chk("R9 eoi 1023 ignored", rv, 32'h20);
    wr(3'd3, 32'd1022);
    rd(3'd4, rv); chk("R9 eoi 1022 ignored", rv, 32'h20);
    wr(3'd3, 32'd5);
    rd(3'd4, rv); chk("R9 eoi inactive ignored", rv, 32'h20);
    irq_req[3] = 1'b0;
    wr(3'd3, 32'd3);
    chk_irq("R8 next candidate right after eoi", 1'b1);
    rd(3'd4, rv); chk("R8 runpri popped to 70", rv, 32'h70);
    set_prio(5, 8'h70);
    chk_irq("R7 equal priority no preempt", 1'b0);
    set_prio(5, 8'h30);
    rd(3'd2, rv); chk("R8 ack src5", rv, 32'd5);
    irq_req[5] = 1'b0;
    wr(3'd3, 32'd5);
    rd(3'd4, rv); chk("R8 runpri back to 70", rv, 32'h70);
    wr(3'd3, 32'd7);
    rd(3'd4, rv); chk("R8 runpri idle", rv, 32'hFF);
    chk_irq("R8 level src7 reoffered", 1'b1);
    irq_req = '0;
    chk_irq("R8 nothing left", 1'b0);

    // R10 edge capture on a peripheral source
    edge_mode[4] = 1'b1; set_prio(4, 8'h10);
    irq_req[4] = 1'b1;
    rd(3'd5, rv); chk("R10 edge pending", rv, 32'd4);
    rd(3'd2, rv); chk("R10 ack edge src", rv, 32'd4);
    rd(3'd5, rv); chk("R10 pending cleared while line high", rv, 32'd1023);
    wr(3'd3, 32'd4);
    chk_irq("R10 held line does not repend", 1'b0);
    irq_req[4] = 1'b0;
    @(negedge clk);
    irq_req[4] = 1'b1;
    @(negedge clk);
    chk_irq("R10 new edge pends", 1'b1);
    rd(3'd2, rv); chk("R10 second ack", rv, 32'd4);
    wr(3'd3, 32'd4);
    irq_req[4] = 1'b0;

    // R5 software sources carry the requester core
    set_prio(0, 8'h08); set_prio(1, 8'h08);
    irq_req[0] = 1'b1;
    @(negedge clk);
    irq_req[0] = 1'b0;
    rd(3'd5, rv); chk("R5 hipend sgi0 core field", rv, 32'h1400);
    rd(3'd2, rv); chk("R5 ack sgi0 core field", rv, 32'h1400);
    wr(3'd3, 32'h1400);
    rd(3'd4, rv); chk("R8 packed eoi retires sgi0", rv, 32'hFF);
    irq_req[1] = 1'b1;
    @(negedge clk);
    irq_req[1] = 1'b0;
    rd(3'd2, rv); chk("R5 ack sgi1 core field", rv, 32'h0801);
    wr(3'd3, 32'h0801);
    rd(3'd5, rv); chk("R10 sgi pulse consumed", rv, 32'd1023);

    // R11 spurious acknowledges
    rd(3'd2, rv); chk("R11 ack with nothing pending", rv, 32'd1023);
    irq_req[5] = 1'b1;
    wr(3'd1, 32'd0);
    chk_irq("R3 mask zero blocks", 1'b0);
    rd(3'd2, rv); chk("R11 ack while masked", rv, 32'd1023);
    rd(3'd5, rv); chk("R11 masked source still pending", rv, 32'd5);
    rd(3'd4, rv); chk("R11 runpri unchanged", rv, 32'hFF);
    irq_req = '0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule